// File: doc/BRIEF.md
# Dual-Event Performance Counter with Snapshot Registers

This block counts two independently chosen events taken from a wide vector of event lines. Each counter watches one line, selected by a programmable field, and adds one for every clock in which that line is high while counting is switched on. Both counters are wider than the 32-bit data bus. The extra bits above the low word come back through fields in the event-control register.

Software does not read the live counters. A snapshot command copies both counters into shadow registers on the same clock edge, so the two values always belong to the same instant. A typical measurement writes a combined clear-and-start command. It waits for the measurement interval. It then writes a combined stop-and-snapshot command and reads the shadow values. Software rebuilds each full count from the low word and the matching upper field.

The register port is a plain single-cycle interface: one write enable, one read enable, an address, and 32-bit write and read data. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. The word index comes from address bits [3:2].

Top module: `dual_event_counter`

## Requirements
- R1: After reset, both live counters, both shadow registers, both select fields and the run bit are zero, and every register reads back as zero.
- R2: The register at offset 0x0 holds counter 0's select code in bits [7:0] and counter 1's select code in bits [15:8]. These fields are writable and read back as written. A code N picks event line N (for example, 40 and 104).
- R3: The register at offset 0x4 holds the run bit in bit 0, and only that bit reads back. Bits [31:1] read as zero. While the run bit is 1, a counter adds exactly one on each clock in which its selected line is high. While the run bit is 0, the counter holds. A write to the run bit takes effect from the next cycle.
- R4: Writing offset 0x4 with bit 2 set clears both live counters on that clock edge. The clear wins over any increment in the same cycle. A write of 0x5 clears both counters and starts counting.
- R5: Writing offset 0x4 with bit 1 set copies both live counters into their shadow registers. The copy takes the values from before that cycle's increment. A write of 0x2 stops counting and takes the snapshot at once.
- R6: Offset 0x8 returns the low word of shadow 0, and offset 0xC returns the low word of shadow 1. Read data is registered: it shows the addressed value one cycle after the read enable, and it holds while the read enable is low.
- R7: Bits [23:16] and [31:24] of offset 0x0 return the shadow bits above the low word, for counter 0 and counter 1 respectively. Writes to these bits are ignored.
- R8: A shadow register changes only on a snapshot command. A clear command or a change of run state leaves it untouched.
- R9: A select code at or above the number of event lines (128 by default) picks no event, so that counter never advances.
- R10: A counter wraps modulo 2^CNT_W. A carry out of the low word shows up in the upper field after the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_vec | input | EVT_W (128) | Event lines, one count per high cycle |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_addr | input | ADDR_W (4) | Byte address; bits [3:2] select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The hardest behaviour to reach from the ports is the carry out of the low word and the wrap of the full counter. At the default widths, that needs more than four billion counted cycles. The bench therefore runs a second, narrow instance beside the default one, with a 4-bit low word and a 6-bit counter. Both instances share the same inputs. A held event line drives the narrow instance past a carry and then through a full wrap, with snapshots taken mid-run. Random traffic mixes control writes and select codes above the event range into the run, and checks every read against a model kept in the bench.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;
  // Word index taken from address bits [3:2]
  typedef enum logic [1:0] {
    WIDX_EVT  = 2'd0,
    WIDX_CTL  = 2'd1,
    WIDX_LOW0 = 2'd2,
    WIDX_LOW1 = 2'd3
  } word_idx_e;

  // Bit positions in the count-control register
  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_SNAP_BIT = 1;
  localparam int CTL_CLR_BIT  = 2;

  // Field pitch inside the event-control register
  localparam int FIELD_W      = 8;
  localparam int UPPER_BASE   = 16;
endpackage

// File: rtl/pc_event_pick.sv
module pc_event_pick #(
  parameter int EVT_W = 128,
  parameter int SEL_W = 8
) (
  input  logic [EVT_W-1:0] event_vec,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [EVT_W-1:0] match;

  // One comparator per line; codes outside the vector match nothing
  for (genvar j = 0; j < EVT_W; j++) begin : g_dec
    assign match[j] = (sel == SEL_W'(j)) && event_vec[j];
  end

  assign hit = |match;
endmodule

// File: rtl/pc_count_lane.sv
module pc_count_lane #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hit,
  input  logic             clr,
  input  logic             snap,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] shadow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
    end else if (clr) begin
      live <= '0;
    end else if (run && hit) begin
      live <= live + CNT_W'(1);
    end
  end

  // Snapshot samples the pre-edge value, so it ignores this cycle's step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (snap) begin
      shadow <= live;
    end
  end
endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
  import perfcnt_pkg::*;
#(
  parameter int EVT_W  = 128,
  parameter int SEL_W  = 8,
  parameter int CNT_W  = 40,
  parameter int LO_W   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  event_vec,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int NUM_CNT = 2;
  localparam int UP_W    = CNT_W - LO_W;

  logic [1:0]                          widx;
  logic                                wr_evt, wr_ctl;
  logic                                clr_cmd, snap_cmd;
  logic                                run_q;
  logic [NUM_CNT-1:0][SEL_W-1:0]       sel_q;
  logic [NUM_CNT-1:0]                  hit_w;
  logic [NUM_CNT-1:0][CNT_W-1:0]       live_w;
  logic [NUM_CNT-1:0][CNT_W-1:0]       shadow_w;
  logic [31:0]                         rd_next;
  logic                                unused_bits;

  assign widx     = reg_addr[3:2];
  assign wr_evt   = reg_we && (widx == WIDX_EVT);
  assign wr_ctl   = reg_we && (widx == WIDX_CTL);
  assign clr_cmd  = wr_ctl && reg_wdata[CTL_CLR_BIT];
  assign snap_cmd = wr_ctl && reg_wdata[CTL_SNAP_BIT];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:UPPER_BASE]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (wr_ctl) begin
      run_q <= reg_wdata[CTL_RUN_BIT];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= '0;
      end else if (wr_evt) begin
        sel_q[i] <= reg_wdata[i*FIELD_W +: SEL_W];
      end
    end

    pc_event_pick #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_pick (
      .event_vec (event_vec),
      .sel       (sel_q[i]),
      .hit       (hit_w[i])
    );

    pc_count_lane #(.CNT_W(CNT_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .hit    (hit_w[i]),
      .clr    (clr_cmd),
      .snap   (snap_cmd),
      .live   (live_w[i]),
      .shadow (shadow_w[i])
    );
  end

  always_comb begin
    rd_next = '0;
    unique case (widx)
      WIDX_EVT: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          rd_next[i*FIELD_W +: SEL_W] = sel_q[i];
          rd_next[UPPER_BASE + i*FIELD_W +: UP_W] = shadow_w[i][CNT_W-1:LO_W];
        end
      end
      WIDX_CTL:  rd_next[CTL_RUN_BIT] = run_q;
      WIDX_LOW0: rd_next[LO_W-1:0] = shadow_w[0][LO_W-1:0];
      WIDX_LOW1: rd_next[LO_W-1:0] = shadow_w[1][LO_W-1:0];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      reg_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/dual_event_counter_chk.sv
module dual_event_counter_chk #(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic                          reg_re,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [31:0]                   reg_wdata,
  input logic [31:0]                   reg_rdata,
  input logic                          run,
  input logic [NUM_CNT-1:0][CNT_W-1:0] live,
  input logic [NUM_CNT-1:0][CNT_W-1:0] shadow
);
  logic ctl_wr, clr_wr, snap_wr;
  assign ctl_wr  = reg_we && (reg_addr[3:2] == 2'd1);
  assign clr_wr  = ctl_wr && reg_wdata[2];
  assign snap_wr = ctl_wr && reg_wdata[1];

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (live == '0));

  p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |=> (shadow == $past(live)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_wr |=> $stable(shadow));

  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr_wr) |=> $stable(live));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_step
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((live[i] == $past(live[i])) ||
                   (live[i] == $past(live[i]) + CNT_W'(1))));
  end
endmodule

bind dual_event_counter dual_event_counter_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .run       (run_q),
  .live      (live_w),
  .shadow    (shadow_w)
);

// File: tb/test_dual_event_counter.sv
`timescale 1ns/1ps
module test_dual_event_counter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] event_vec = '0;
  logic         reg_we = 1'b0;
  logic         reg_re = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  rdata_w, rdata_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Bench model: index 0 = default instance, 1 = narrow instance
  logic [63:0] m_live [2][2];
  logic [63:0] m_sh   [2][2];
  logic [7:0]  m_sel  [2];
  logic        m_run;
  logic [31:0] last_e [2];

  always #10 clk = ~clk;

  dual_event_counter i_dual_event_counter (
    .clk(clk), .rst_n(rst_n), .event_vec(event_vec), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_w));

  dual_event_counter #(.CNT_W(6), .LO_W(4)) i_dual_event_counter_narrow (
    .clk(clk), .rst_n(rst_n), .event_vec(event_vec), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_n));

  function automatic int cw(int inst); return inst ? 6 : 40; endfunction
  function automatic int lw(int inst); return inst ? 4 : 32; endfunction

  function automatic logic [31:0] rd_model(int inst, logic [1:0] idx);
    logic [31:0] v = '0;
    logic [63:0] lm = (64'd1 << lw(inst)) - 64'd1;
    case (idx)
      2'd0: begin
        v[7:0]   = m_sel[0];
        v[15:8]  = m_sel[1];
        v[23:16] = 8'(m_sh[inst][0] >> lw(inst));
        v[31:24] = 8'(m_sh[inst][1] >> lw(inst));
      end
      2'd1: v[0] = m_run;
      2'd2: v = 32'(m_sh[inst][0] & lm);
      default: v = 32'(m_sh[inst][1] & lm);
    endcase
    return v;
  endfunction

  task automatic model_tick(logic we, logic [3:0] a, logic [31:0] wd, logic [127:0] ev);
    logic ctl = we && (a[3:2] == 2'd1);
    for (int i = 0; i < 2; i++) begin
      for (int l = 0; l < 2; l++) begin
        logic hit = (m_sel[l] < 8'd128) && ev[m_sel[l][6:0]];
        logic [63:0] cm = (64'd1 << cw(i)) - 64'd1;
        if (ctl && wd[1]) m_sh[i][l] = m_live[i][l];
        if (ctl && wd[2]) m_live[i][l] = '0;
        else if (m_run && hit) m_live[i][l] = (m_live[i][l] + 64'd1) & cm;
      end
    end
    if (we && a[3:2] == 2'd0) begin m_sel[0] = wd[7:0]; m_sel[1] = wd[15:8]; end
    if (ctl) m_run = wd[0];
  endtask

  task automatic check(string tag, int inst, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s inst%0d: got %h expected %h", tag, inst, got, exp);
    end
  endtask

  task automatic step(logic we, logic re, logic [3:0] a, logic [31:0] wd,
                      logic [127:0] ev, string tag);
    logic [31:0] e0, e1;
    reg_we = we; reg_re = re; reg_addr = a; reg_wdata = wd; event_vec = ev;
    e0 = rd_model(0, a[3:2]);
    e1 = rd_model(1, a[3:2]);
    model_tick(we, a, wd, ev);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b0;
    if (re) begin
      last_e[0] = e0; last_e[1] = e1;
      check(tag, 0, rdata_w, e0);
      check(tag, 1, rdata_n, e1);
    end
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 4'(k*4), '0, event_vec, tag);
  endtask

  function automatic logic [127:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    for (int i = 0; i < 2; i++)
      for (int l = 0; l < 2; l++) begin m_live[i][l] = '0; m_sh[i][l] = '0; end
    m_sel[0] = '0; m_sel[1] = '0; m_run = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything zero after reset
    read_all("R1 reset");

    // R2: select codes 40 and 104
    step(1'b1, 1'b0, 4'h0, 32'h0000_6828, '0, "R2");
    step(1'b0, 1'b1, 4'h0, '0, '0, "R2 select readback");

    // R4: clear and start; R3: count selected lines
    step(1'b1, 1'b0, 4'h4, 32'h5, '0, "R4");
    for (int n = 0; n < 50; n++) step(1'b0, 1'b0, 4'h0, '0, rnd_vec(), "R3");
    // R5: stop and snapshot in one write, with events still active
    step(1'b1, 1'b0, 4'h4, 32'h2, {128{1'b1}}, "R5");
    read_all("R5 R6 snapshot");
    step(1'b0, 1'b0, 4'h8, '0, '0, "R6 idle");
    check("R6 rdata holds", 0, rdata_w, last_e[0]);

    // R7: writes to upper fields ignored
    step(1'b1, 1'b0, 4'h0, 32'hFFFF_0303, '0, "R7");
    step(1'b0, 1'b1, 4'h0, '0, '0, "R7 upper read-only");

    // R10: hold line 3 high; snapshot at 40 counts (carry), then past wrap
    step(1'b1, 1'b0, 4'h4, 32'h5, '0, "R10");
    for (int n = 0; n < 40; n++) step(1'b0, 1'b0, 4'h0, '0, 128'h8, "R10");
    step(1'b1, 1'b0, 4'h4, 32'h3, 128'h8, "R10 snapshot mid-run");
    read_all("R10 carry");
    for (int n = 0; n < 30; n++) step(1'b0, 1'b0, 4'h0, '0, 128'h8, "R10");
    step(1'b1, 1'b0, 4'h4, 32'h2, 128'h8, "R10");
    read_all("R10 wrap");

    // R8: clear and run changes leave the shadow intact
    step(1'b1, 1'b0, 4'h4, 32'h5, 128'h8, "R8");
    for (int n = 0; n < 5; n++) step(1'b0, 1'b0, 4'h0, '0, 128'h8, "R8");
    step(1'b1, 1'b0, 4'h4, 32'h4, 128'h8, "R8");
    read_all("R8 shadow held");

    // R9: out-of-range select with all lines high
    step(1'b1, 1'b0, 4'h0, 32'h0000_80C8, '0, "R9");
    step(1'b1, 1'b0, 4'h4, 32'h5, '1, "R9");
    for (int n = 0; n < 20; n++) step(1'b0, 1'b0, 4'h0, '0, '1, "R9");
    step(1'b1, 1'b0, 4'h4, 32'h2, '1, "R9");
    read_all("R9 no count");

    // Random traffic mixed with reads (R2 R3 R4 R5 R6 R7 R9)
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom % 100;
      logic [31:0] wd;
      if (r < 4) begin
        int unsigned pick = $urandom % 4;
        logic [7:0] s0 = (pick == 0) ? 8'd40 : (pick == 1) ? 8'($urandom % 256) : 8'($urandom % 128);
        logic [7:0] s1 = (pick == 0) ? 8'd104 : 8'($urandom % 256);
        wd = {$urandom} & 32'hFFFF_0000;
        step(1'b1, 1'b0, 4'h0, wd | {16'h0, s1, s0}, rnd_vec(), "R2 random");
      end else if (r < 12) begin
        wd = {$urandom} & 32'hFFFF_FFF8;
        wd[0] = ($urandom % 4) != 0;
        wd[1] = ($urandom % 2);
        wd[2] = ($urandom % 6) == 0;
        step(1'b1, 1'b0, 4'h4, wd, rnd_vec(), "R4 random");
      end else if (r < 30) begin
        step(1'b0, 1'b1, 4'(($urandom % 4) * 4 + ($urandom % 4)), '0, rnd_vec(),
             "R6 random read");
      end else begin
        step(1'b0, 1'b0, 4'h0, '0, rnd_vec(), "R3 random");
      end
    end
    step(1'b1, 1'b0, 4'h4, 32'h2, '0, "R5 final");
    read_all("R5 final snapshot");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule